// File: doc/BRIEF.md
# Radio Transceiver Mode Sequencer

This block sits on the host side of a two-channel FSK radio. It drives the radio's three mode pins: power-up, transmit enable and channel select. It takes a mode request (standby, receive or transmit) and a channel request, and applies the matching pin pattern. It then holds the data path closed until the radio has settled. During that time the outgoing serial bit is forced to an idle level, and received bits are marked invalid until the receiver can be trusted.

The wait before data depends on the pin state that is actually applied and on the requested mode. The first entry into an operating mode after the supply becomes stable counts as a cold start, and a cold start has its own, longer waits. On a cold start into transmit, transmit enable is held low while the synthesiser settles. All waits are given in microseconds and converted to clock cycles through a clock-frequency parameter. The conversion rounds up, so a wait is never shorter than its setting.

Top module: `radio_mode_seq`

## Requirements
- R1: A standby request (mode code 00, and code 11 is treated the same) drives power-up and transmit enable low and raises ready on the edge that applies it, with no wait.
- R2: An operating request drives power-up high. Transmit enable is high for transmit (code 10) and low for receive (code 01). The channel pin equals the channel request (0 = first channel, 1 = second).
- R3: Receive to transmit: ready rises 1 ms after transmit enable goes high.
- R4: Transmit to receive: ready rises 3 ms after transmit enable goes low.
- R5: Standby to receive (not cold): ready rises 3 ms after power-up rises.
- R6: Standby to transmit (not cold): ready rises 2 ms after power-up rises.
- R7: A cold start into transmit holds transmit enable low for 3 ms after power-up rises, then raises it; ready comes 4 ms after power-up.
- R8: A cold start into receive waits 5 ms, or 3 ms when the external-reference input is high.
- R9: While ready is low, the outgoing data pin sits at the idle level (0) and the received-data-valid flag is low. Once ready is high, the outgoing pin follows the transmit bit in transmit mode, and valid is high with the received bit passed through in receive mode.
- R10: A new request made during a wait aborts it and restarts timing from the pins then applied.
- R11: A channel change while operating re-enters the mode: 3 ms in receive, 1 ms in transmit.
- R12: While supply-stable is low, all pins are low, ready is low, and the next operating entry is a cold start.
- R13: Transmit enable is never high while power-up is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Radio supply is stable |
| ext_ref | input | 1 | External reference oscillator in use (shortens a cold receive wait) |
| mode_req | input | 2 | Requested mode: 00 standby, 01 receive, 10 transmit, 11 standby |
| chan_req | input | 1 | Requested channel |
| tx_bit | input | 1 | Outgoing serial bit from the host |
| rx_pin | input | 1 | Demodulated bit from the radio |
| pin_pwr | output | 1 | Radio power-up pin |
| pin_txen | output | 1 | Radio transmit-enable pin |
| pin_chan | output | 1 | Radio channel-select pin |
| pin_txd | output | 1 | Gated serial bit to the radio |
| rx_bit | output | 1 | Qualified received bit |
| rx_valid | output | 1 | Received bit is valid |
| ready | output | 1 | Current mode has settled |

## Verification
The directed part runs every ordered pair of modes: cold and warm starts, with and without the external reference, channel changes in each direction, and a request that aborts a wait in progress. Each case has a distinct expected wait, so a swapped or misrouted delay shows up as a wrong cycle count. Random requests, including repeats of the current request and the spare mode code, are checked against a bench model of the pins and waits. This separates a true re-entry from a request that must have no effect. The gate is held with both data inputs high during every wait, so a data path that opens too early is caught.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SB   = 2'b00,
    MODE_RX   = 2'b01,
    MODE_TX   = 2'b10,
    MODE_NONE = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAIT,
    ST_SYNTH,
    ST_RUN
  } seq_st_e;

  // Round up so a wait is never shorter than asked.
  function automatic int unsigned us_to_cycles(input int unsigned us,
                                               input int unsigned khz);
    return (us * khz + 999) / 1000;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_delay_sel.sv
module seq_delay_sel
  import radio_seq_pkg::*;
#(
  parameter int unsigned CW               = 8,
  parameter int unsigned CLK_KHZ          = 16000,
  parameter int unsigned T_RX2TX_US       = 1000,
  parameter int unsigned T_TX2RX_US       = 3000,
  parameter int unsigned T_SB2RX_US       = 3000,
  parameter int unsigned T_SB2TX_US       = 2000,
  parameter int unsigned T_COLD_SYN_US    = 3000,
  parameter int unsigned T_COLD_TX_US     = 4000,
  parameter int unsigned T_COLD_RX_US     = 5000,
  parameter int unsigned T_COLD_RX_EXT_US = 3000
) (
  input  logic          cold,
  input  logic          ext_ref,
  input  logic          pwr_on,
  input  mode_e         to_mode,
  output logic [CW-1:0] first_cyc,
  output logic          synth_first,
  output logic [CW-1:0] second_cyc
);
  localparam logic [CW-1:0] C_RX2TX   = CW'(us_to_cycles(T_RX2TX_US, CLK_KHZ));
  localparam logic [CW-1:0] C_TX2RX   = CW'(us_to_cycles(T_TX2RX_US, CLK_KHZ));
  localparam logic [CW-1:0] C_SB2RX   = CW'(us_to_cycles(T_SB2RX_US, CLK_KHZ));
  localparam logic [CW-1:0] C_SB2TX   = CW'(us_to_cycles(T_SB2TX_US, CLK_KHZ));
  localparam logic [CW-1:0] C_CSYN    = CW'(us_to_cycles(T_COLD_SYN_US, CLK_KHZ));
  localparam logic [CW-1:0] C_CTXON   = CW'(us_to_cycles(T_COLD_TX_US - T_COLD_SYN_US, CLK_KHZ));
  localparam logic [CW-1:0] C_CRX     = CW'(us_to_cycles(T_COLD_RX_US, CLK_KHZ));
  localparam logic [CW-1:0] C_CRX_EXT = CW'(us_to_cycles(T_COLD_RX_EXT_US, CLK_KHZ));

  assign second_cyc = C_CTXON;

  always_comb begin
    first_cyc   = '0;
    synth_first = 1'b0;
    case (to_mode)
      MODE_RX: begin
        if (cold)        first_cyc = ext_ref ? C_CRX_EXT : C_CRX;
        else if (pwr_on) first_cyc = C_TX2RX;
        else             first_cyc = C_SB2RX;
      end
      MODE_TX: begin
        if (cold) begin
          synth_first = 1'b1;
          first_cyc   = C_CSYN;
        end else begin
          first_cyc = pwr_on ? C_RX2TX : C_SB2TX;
        end
      end
      default: first_cyc = '0;
    endcase
  end
endmodule

// File: rtl/seq_settle_timer.sv
module seq_settle_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear)         cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign expire = (cnt == CW'(1));
endmodule

// File: rtl/seq_data_gate.sv
module seq_data_gate #(
  parameter logic IDLE_TXD = 1'b0
) (
  input  logic ready,
  input  logic pwr,
  input  logic txen,
  input  logic tx_bit,
  input  logic rx_pin,
  output logic txd,
  output logic rx_valid,
  output logic rx_bit
);
  assign txd      = (ready && txen) ? tx_bit : IDLE_TXD;
  assign rx_valid = ready && pwr && !txen;
  assign rx_bit   = rx_valid && rx_pin;
endmodule

// File: rtl/radio_mode_seq.sv
module radio_mode_seq
  import radio_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ          = 16000,
  parameter int unsigned T_RX2TX_US       = 1000,
  parameter int unsigned T_TX2RX_US       = 3000,
  parameter int unsigned T_SB2RX_US       = 3000,
  parameter int unsigned T_SB2TX_US       = 2000,
  parameter int unsigned T_COLD_SYN_US    = 3000,
  parameter int unsigned T_COLD_TX_US     = 4000,
  parameter int unsigned T_COLD_RX_US     = 5000,
  parameter int unsigned T_COLD_RX_EXT_US = 3000,
  parameter logic        IDLE_TXD         = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       ext_ref,
  input  logic [1:0] mode_req,
  input  logic       chan_req,
  input  logic       tx_bit,
  input  logic       rx_pin,
  output logic       pin_pwr,
  output logic       pin_txen,
  output logic       pin_chan,
  output logic       pin_txd,
  output logic       rx_bit,
  output logic       rx_valid,
  output logic       ready
);
  localparam int unsigned MAX_US = umax(umax(umax(T_RX2TX_US, T_TX2RX_US),
                                             umax(T_SB2RX_US, T_SB2TX_US)),
                                        umax(umax(T_COLD_TX_US, T_COLD_RX_US),
                                             T_COLD_RX_EXT_US));
  localparam int unsigned MAX_CYC = us_to_cycles(MAX_US, CLK_KHZ);
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  seq_st_e       state;
  mode_e         tgt_mode;
  logic          tgt_chan;
  logic          cold;
  mode_e         req_n;

  // Named internal events, also seen by the checker.
  logic          req_change;
  logic          req_change_op;
  logic          timer_expire;
  logic          synth_phase;
  logic          synth_done;

  logic [CW-1:0] first_cyc, second_cyc;
  logic          synth_first;

  assign req_n         = (mode_req == 2'b11) ? MODE_SB : mode_e'(mode_req);
  assign req_change    = supply_ok &&
                         ((tgt_mode != req_n) || (req_n != MODE_SB && chan_req != tgt_chan));
  assign req_change_op = req_change && (req_n != MODE_SB);
  assign synth_phase   = (state == ST_SYNTH);
  assign synth_done    = synth_phase && timer_expire && !req_change;

  seq_delay_sel #(
    .CW(CW), .CLK_KHZ(CLK_KHZ),
    .T_RX2TX_US(T_RX2TX_US), .T_TX2RX_US(T_TX2RX_US),
    .T_SB2RX_US(T_SB2RX_US), .T_SB2TX_US(T_SB2TX_US),
    .T_COLD_SYN_US(T_COLD_SYN_US), .T_COLD_TX_US(T_COLD_TX_US),
    .T_COLD_RX_US(T_COLD_RX_US), .T_COLD_RX_EXT_US(T_COLD_RX_EXT_US)
  ) delay_i (
    .cold(cold), .ext_ref(ext_ref), .pwr_on(pin_pwr), .to_mode(req_n),
    .first_cyc(first_cyc), .synth_first(synth_first), .second_cyc(second_cyc)
  );

  seq_settle_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .clear(!supply_ok),
    .load(req_change_op || synth_done),
    .load_val(req_change_op ? first_cyc : second_cyc),
    .expire(timer_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      pin_pwr  <= 1'b0;
      pin_txen <= 1'b0;
      pin_chan <= 1'b0;
      tgt_mode <= MODE_NONE;
      tgt_chan <= 1'b0;
      cold     <= 1'b1;
    end else if (!supply_ok) begin
      state    <= ST_OFF;
      pin_pwr  <= 1'b0;
      pin_txen <= 1'b0;
      pin_chan <= 1'b0;
      tgt_mode <= MODE_NONE;
      cold     <= 1'b1;
    end else if (req_change) begin
      tgt_mode <= req_n;
      tgt_chan <= chan_req;
      case (req_n)
        MODE_RX: begin
          pin_pwr  <= 1'b1;
          pin_txen <= 1'b0;
          pin_chan <= chan_req;
          state    <= ST_WAIT;
        end
        MODE_TX: begin
          pin_pwr  <= 1'b1;
          pin_txen <= !synth_first;
          pin_chan <= chan_req;
          state    <= synth_first ? ST_SYNTH : ST_WAIT;
        end
        default: begin
          pin_pwr  <= 1'b0;
          pin_txen <= 1'b0;
          pin_chan <= 1'b0;
          state    <= ST_RUN;
        end
      endcase
    end else begin
      case (state)
        ST_SYNTH: if (timer_expire) begin
          pin_txen <= 1'b1;
          state    <= ST_WAIT;
        end
        ST_WAIT: if (timer_expire) begin
          state <= ST_RUN;
          if (pin_pwr) cold <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign ready = (state == ST_RUN);

  seq_data_gate #(.IDLE_TXD(IDLE_TXD)) gate_i (
    .ready(ready), .pwr(pin_pwr), .txen(pin_txen), .tx_bit(tx_bit),
    .rx_pin(rx_pin), .txd(pin_txd), .rx_valid(rx_valid), .rx_bit(rx_bit)
  );
endmodule

// File: rtl/radio_mode_seq_chk.sv
module radio_mode_seq_chk #(
  parameter logic IDLE_TXD = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic pin_pwr,
  input logic pin_txen,
  input logic pin_txd,
  input logic ready,
  input logic synth_phase,
  input logic req_change_op
);
  AST_TXEN_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    pin_txen |-> pin_pwr); // R13

  AST_TXD_IDLE_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (pin_txd == IDLE_TXD)); // R9

  AST_SUPPLY_DROP_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!pin_pwr && !pin_txen && !ready)); // R12

  AST_SYNTH_TXEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    synth_phase |-> !pin_txen); // R7

  AST_REQ_RESTARTS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_change_op |=> !ready); // R10

  AST_TXEN_RISE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_txen) |-> !ready); // R3
endmodule

bind radio_mode_seq radio_mode_seq_chk #(.IDLE_TXD(IDLE_TXD)) chk_i (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pin_pwr(pin_pwr),
  .pin_txen(pin_txen), .pin_txd(pin_txd), .ready(ready),
  .synth_phase(synth_phase), .req_change_op(req_change_op)
);

// File: tb/radio_mode_seq_tb_top.sv
`timescale 1ns/1ps
module radio_mode_seq_tb_top;
  // 10 cycles per millisecond keeps every wait short.
  localparam int MS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic ext_ref = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic chan_req = 1'b0;
  logic tx_bit = 1'b0;
  logic rx_pin = 1'b0;
  logic pin_pwr, pin_txen, pin_chan, pin_txd, rx_bit, rx_valid, ready;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench model of what has been applied.
  logic [1:0] cur_mode = 2'b00;
  logic cur_chan = 1'b0;

  always #5 clk = ~clk;

  radio_mode_seq #(.CLK_KHZ(MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ext_ref(ext_ref),
    .mode_req(mode_req), .chan_req(chan_req), .tx_bit(tx_bit), .rx_pin(rx_pin),
    .pin_pwr(pin_pwr), .pin_txen(pin_txen), .pin_chan(pin_chan),
    .pin_txd(pin_txd), .rx_bit(rx_bit), .rx_valid(rx_valid), .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] norm(input logic [1:0] m);
    return (m == 2'b11) ? 2'b00 : m;
  endfunction

  // Warm wait in cycles for a request, from the bench's own reading of the rules.
  function automatic int warm_wait(input logic [1:0] from_m, input logic from_c,
                                   input logic [1:0] to_m, input logic to_c);
    if (to_m == 2'b00) return 0;
    if (to_m == from_m && to_c == from_c) return 0;
    if (to_m == 2'b01) return 3 * MS;
    return (from_m == 2'b00) ? 2 * MS : 1 * MS;
  endfunction

  task automatic check_pins(input string tag);
    logic [2:0] act, exp;
    act = {pin_pwr, pin_txen, pin_chan};
    if (cur_mode == 2'b00) exp = 3'b000;
    else exp = {1'b1, cur_mode == 2'b10, cur_chan};
    check(act == exp, tag, int'(act), int'(exp));
  endtask

  // Apply a request and count cycles until ready; data gate watched meanwhile.
  task automatic do_req(input logic [1:0] m, input logic c, input int exp, input string tag);
    int cnt;
    bit gate_bad;
    @(negedge clk);
    mode_req = m; chan_req = c; tx_bit = 1'b1; rx_pin = 1'b1;
    @(posedge clk);
    cnt = 0; gate_bad = 0;
    @(negedge clk);
    while (!ready && cnt < 300) begin
      if (pin_txd != 1'b0 || rx_valid) gate_bad = 1;
      cnt++;
      @(negedge clk);
    end
    check(cnt == exp, tag, cnt, exp);
    check(!gate_bad, "R9 gate closed during wait", int'(gate_bad), 0);
    cur_mode = norm(m);
    if (norm(m) != 2'b00) cur_chan = c;
    check_pins({"R2 pins after ", tag});
  endtask

  task automatic drop_supply();
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk);
    check({pin_pwr, pin_txen, pin_chan, ready} == 4'b0, "R12 supply low forces standby",
          int'({pin_pwr, pin_txen, pin_chan, ready}), 0);
    @(negedge clk); mode_req = 2'b00; supply_ok = 1'b1;
    @(negedge clk);
    cur_mode = 2'b00;
    check(ready == 1'b1, "R1 standby after supply return", int'(ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check({pin_pwr, pin_txen, pin_chan, pin_txd, rx_valid, ready} == 6'b0,
          "R12 reset state", int'({pin_pwr, pin_txen, pin_chan, pin_txd, rx_valid, ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b0, "R12 no ready without supply", int'(ready), 0);
    supply_ok = 1'b1;
    @(negedge clk); @(negedge clk);
    check(ready && !pin_pwr && !pin_txen, "R1 standby on supply", int'(ready), 1);

    // R8: cold receive, internal reference.
    do_req(2'b01, 1'b0, 5 * MS, "R8 cold rx 5ms");
    @(negedge clk); rx_pin = 1'b1;
    @(negedge clk);
    check(rx_valid && rx_bit, "R9 rx valid passes bit", int'({rx_valid, rx_bit}), 3);
    rx_pin = 1'b0; @(negedge clk);
    check(rx_valid && !rx_bit, "R9 rx bit low", int'(rx_bit), 0);

    do_req(2'b10, 1'b0, 1 * MS, "R3 rx to tx");
    tx_bit = 1'b0; @(negedge clk);
    check(pin_txd == 1'b0 && !rx_valid, "R9 txd follows 0", int'(pin_txd), 0);
    tx_bit = 1'b1; @(negedge clk);
    check(pin_txd == 1'b1, "R9 txd follows 1", int'(pin_txd), 1);

    do_req(2'b01, 1'b0, 3 * MS, "R4 tx to rx");
    do_req(2'b01, 1'b1, 3 * MS, "R11 rx channel change");
    do_req(2'b10, 1'b1, 1 * MS, "R3 rx to tx ch2");
    do_req(2'b10, 1'b0, 1 * MS, "R11 tx channel change");
    do_req(2'b00, 1'b0, 0, "R1 tx to standby");
    do_req(2'b01, 1'b1, 3 * MS, "R5 standby to rx");
    do_req(2'b11, 1'b0, 0, "R1 spare code is standby");
    do_req(2'b10, 1'b1, 2 * MS, "R6 standby to tx");
    do_req(2'b00, 1'b0, 0, "R1 standby");

    // R10: abort a running receive wait with a transmit request.
    @(negedge clk); mode_req = 2'b01; chan_req = 1'b0;
    repeat (6) @(negedge clk);
    check(ready == 1'b0 && pin_pwr, "R10 wait in progress", int'(ready), 0);
    do_req(2'b10, 1'b0, 1 * MS, "R10 abort restarts from applied pins");

    // R7: cold start into transmit.
    drop_supply();
    begin
      int t_on, t_rdy;
      @(negedge clk); mode_req = 2'b10; chan_req = 1'b1;
      @(posedge clk);
      t_on = 0; t_rdy = 0;
      @(negedge clk);
      while (!pin_txen && t_on < 300) begin t_on++; t_rdy++; @(negedge clk); end
      check(t_on == 3 * MS, "R7 txen low while synth settles", t_on, 3 * MS);
      while (!ready && t_rdy < 300) begin
        if (pin_txd != 1'b0) t_rdy = 1000;
        t_rdy++; @(negedge clk);
      end
      check(t_rdy == 4 * MS, "R7 cold tx total wait", t_rdy, 4 * MS);
      cur_mode = 2'b10; cur_chan = 1'b1;
      check_pins("R2 pins after cold tx");
    end

    // R8: cold receive with external reference.
    drop_supply();
    ext_ref = 1'b1;
    do_req(2'b01, 1'b0, 3 * MS, "R8 cold rx ext ref 3ms");
    ext_ref = 1'b0;

    // Random warm requests against the bench model.
    for (int i = 0; i < 40; i++) begin
      logic [1:0] m;
      logic c;
      int e;
      m = 2'($urandom_range(0, 3));
      c = 1'($urandom_range(0, 1));
      ext_ref = 1'($urandom_range(0, 1));
      e = warm_wait(cur_mode, cur_chan, norm(m), c);
      do_req(m, c, e, "R11 random request wait");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule